// File: doc/BRIEF.md
# Overload-Driven Gain Index Stepper

This block is the gain-reduction half of an automatic gain control loop. Each time the loop raises a step strobe, the block looks at which overload detectors fired and lowers one or more gain table indices. The surrounding logic maps those indices to gain settings.

The block has two table organisations. With a single combined table, only one index is kept, held in the limiter index register. The amount taken off it depends on how severe the overload is, and comes from one of three programmable step sizes. With split tables, there are separate limiter, low-pass-filter and digital indices. Each overload is sent to one of them, one index per strobe. ADC overloads are drained from the limiter table first. Once the limiter index has fallen to a programmable partition limit, ADC overloads move on to the filter table.

Reset is synchronous. While reset is held, the indices load from their configured start values.

Top module: `gain_index_stepper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `lim_idx`, `lpf_idx` and `dig_idx` load `cfg_lim_max`, `cfg_lpf_init` and `cfg_dig_init`.
- R2: In combined mode (`split_mode`=0), a strobe with a large ADC overload plus a large limiter overload or a digital saturation lowers `lim_idx` by `cfg_step_c1` (4 bits).
- R3: In combined mode, a strobe with any of large ADC, large limiter or digital saturation, where R2 does not apply, lowers `lim_idx` by `cfg_step_c2` (3 bits).
- R4: In combined mode, a strobe with only a small ADC overload lowers `lim_idx` by `cfg_step_c3` (3 bits).
- R5: When several overloads arrive in one strobe, only the most severe applicable case (R2 over R3 over R4) is subtracted, and only once.
- R6: Every index stops at zero instead of wrapping when a reduction would take it below zero.
- R7: In split mode, a large limiter overload lowers `lim_idx` by one.
- R8: In split mode, an ADC overload (large or small) lowers `lim_idx` by one while `lim_idx` > `cfg_lim_floor`. Otherwise it lowers `lpf_idx` by one. The comparison uses the index value before the strobe.
- R9: In split mode, a digital saturation lowers `dig_idx` by one, alongside any limiter or filter change in the same strobe.
- R10: With `step_en` low, or with a strobe that carries no overload flag, every index holds its value.
- R11: In combined mode, `lpf_idx` and `dig_idx` never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the start values |
| split_mode | input | 1 | 1 = separate tables, 0 = single combined table |
| step_en | input | 1 | Gain-reduction strobe |
| ovl_adc_large | input | 1 | Large ADC overload seen |
| ovl_adc_small | input | 1 | Small ADC overload seen |
| ovl_lim_large | input | 1 | Large limiter overload seen |
| ovl_dig_sat | input | 1 | Digital saturation seen |
| cfg_step_c1 | input | 4 | Step for the most severe combined-mode case |
| cfg_step_c2 | input | 3 | Step for the single-large-overload case |
| cfg_step_c3 | input | 3 | Step for the small-ADC-only case |
| cfg_lim_max | input | 7 | Limiter index start value |
| cfg_lim_floor | input | 7 | Partition limit between upper and lower limiter table |
| cfg_lpf_init | input | 6 | Filter index start value |
| cfg_dig_init | input | 5 | Digital index start value |
| lim_idx | output | 7 | Limiter (or combined) index |
| lpf_idx | output | 6 | Filter index |
| dig_idx | output | 5 | Digital index |

## Verification
The assertions check the following on every cycle:
- indices are frozen when no strobe is present;
- the filter and digital indices are untouched in combined mode;
- split-mode steps are at most one index;
- the exact case-1 subtraction and its clamp at zero;
- ADC overloads are sent to the filter table at or below the partition limit.

Only the bench's scenarios can show the following:
- severity ranking across flag combinations;
- the equality boundary of the partition walked down from the top;
- simultaneous digital and filter reductions;
- reset reload after indices have been driven to zero.

// File: rtl/gis_pkg.sv
package gis_pkg;
    typedef enum logic [1:0] {
        SEV_NONE = 2'd0,
        SEV_C3   = 2'd1,
        SEV_C2   = 2'd2,
        SEV_C1   = 2'd3
    } sev_e;
endpackage

// File: rtl/gis_severity.sv
module gis_severity
    import gis_pkg::*;
#(
    parameter int C1_W = 4,
    parameter int C23_W = 3,
    parameter int SW = 4
) (
    input  logic             adc_large,
    input  logic             adc_small,
    input  logic             lim_large,
    input  logic             dig_sat,
    input  logic [C1_W-1:0]  step_c1,
    input  logic [C23_W-1:0] step_c2,
    input  logic [C23_W-1:0] step_c3,
    output sev_e             sev,
    output logic [SW-1:0]    step
);
    always_comb begin
        if (adc_large && (lim_large || dig_sat)) begin
            sev  = SEV_C1;
            step = SW'(step_c1);
        end else if (adc_large || lim_large || dig_sat) begin
            sev  = SEV_C2;
            step = SW'(step_c2);
        end else if (adc_small) begin
            sev  = SEV_C3;
            step = SW'(step_c3);
        end else begin
            sev  = SEV_NONE;
            step = '0;
        end
    end
endmodule

// File: rtl/gis_split_route.sv
module gis_split_route #(
    parameter int LMT_W = 7
) (
    input  logic             adc_large,
    input  logic             adc_small,
    input  logic             lim_large,
    input  logic             dig_sat,
    input  logic [LMT_W-1:0] lim_cur,
    input  logic [LMT_W-1:0] lim_floor,
    output logic             hit_lim,
    output logic             hit_lpf,
    output logic             hit_dig
);
    logic any_adc;
    logic upper;

    always_comb begin
        any_adc = adc_large | adc_small;
        upper   = lim_cur > lim_floor;
        hit_lim = lim_large | (any_adc & upper);
        hit_lpf = any_adc & ~upper;
        hit_dig = dig_sat;
    end
endmodule

// File: rtl/gis_satsub.sv
module gis_satsub #(
    parameter int W = 7,
    parameter int SW = 4
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] s,
    output logic [W-1:0]  y
);
    localparam int MW = (W > SW) ? W : SW;

    logic [MW-1:0] a_ext;
    logic [MW-1:0] s_ext;
    logic [MW-1:0] diff;

    always_comb begin
        a_ext = MW'(a);
        s_ext = MW'(s);
        diff  = a_ext - s_ext;
        y     = (a_ext >= s_ext) ? diff[W-1:0] : '0;
    end
endmodule

// File: rtl/gain_index_stepper.sv
module gain_index_stepper
    import gis_pkg::*;
#(
    parameter int LMT_W = 7,
    parameter int LPF_W = 6,
    parameter int DIG_W = 5,
    parameter int C1_W = 4,
    parameter int C23_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split_mode,
    input  logic             step_en,
    input  logic             ovl_adc_large,
    input  logic             ovl_adc_small,
    input  logic             ovl_lim_large,
    input  logic             ovl_dig_sat,
    input  logic [C1_W-1:0]  cfg_step_c1,
    input  logic [C23_W-1:0] cfg_step_c2,
    input  logic [C23_W-1:0] cfg_step_c3,
    input  logic [LMT_W-1:0] cfg_lim_max,
    input  logic [LMT_W-1:0] cfg_lim_floor,
    input  logic [LPF_W-1:0] cfg_lpf_init,
    input  logic [DIG_W-1:0] cfg_dig_init,
    output logic [LMT_W-1:0] lim_idx,
    output logic [LPF_W-1:0] lpf_idx,
    output logic [DIG_W-1:0] dig_idx
);
    localparam int STEP_W = (C1_W > C23_W) ? C1_W : C23_W;

    typedef struct packed {
        logic [LMT_W-1:0] lim;
        logic [LPF_W-1:0] lpf;
        logic [DIG_W-1:0] dig;
    } idx_t;

    idx_t st_d, st_q;

    sev_e              sev;
    logic [STEP_W-1:0] full_step;
    logic              hit_lim, hit_lpf, hit_dig;
    logic [STEP_W-1:0] lim_step;
    logic              lpf_step, dig_step;
    logic [LMT_W-1:0]  lim_sub;
    logic [LPF_W-1:0]  lpf_sub;
    logic [DIG_W-1:0]  dig_sub;

    gis_severity #(.C1_W(C1_W), .C23_W(C23_W), .SW(STEP_W)) u_sev (
        .adc_large (ovl_adc_large),
        .adc_small (ovl_adc_small),
        .lim_large (ovl_lim_large),
        .dig_sat   (ovl_dig_sat),
        .step_c1   (cfg_step_c1),
        .step_c2   (cfg_step_c2),
        .step_c3   (cfg_step_c3),
        .sev       (sev),
        .step      (full_step)
    );

    gis_split_route #(.LMT_W(LMT_W)) u_route (
        .adc_large (ovl_adc_large),
        .adc_small (ovl_adc_small),
        .lim_large (ovl_lim_large),
        .dig_sat   (ovl_dig_sat),
        .lim_cur   (st_q.lim),
        .lim_floor (cfg_lim_floor),
        .hit_lim   (hit_lim),
        .hit_lpf   (hit_lpf),
        .hit_dig   (hit_dig)
    );

    always_comb begin
        if (!step_en)
            lim_step = '0;
        else if (split_mode)
            lim_step = hit_lim ? STEP_W'(1) : '0;
        else
            lim_step = full_step;
        lpf_step = step_en & split_mode & hit_lpf;
        dig_step = step_en & split_mode & hit_dig;
    end

    gis_satsub #(.W(LMT_W), .SW(STEP_W)) u_sub_lim (.a(st_q.lim), .s(lim_step), .y(lim_sub));
    gis_satsub #(.W(LPF_W), .SW(1))      u_sub_lpf (.a(st_q.lpf), .s(lpf_step), .y(lpf_sub));
    gis_satsub #(.W(DIG_W), .SW(1))      u_sub_dig (.a(st_q.dig), .s(dig_step), .y(dig_sub));

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.lim = cfg_lim_max;
            st_d.lpf = cfg_lpf_init;
            st_d.dig = cfg_dig_init;
        end else begin
            st_d.lim = lim_sub;
            st_d.lpf = lpf_sub;
            st_d.dig = dig_sub;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lim_idx = st_q.lim;
    assign lpf_idx = st_q.lpf;
    assign dig_idx = st_q.dig;

    // R10: no strobe, no movement
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(lim_idx) && $stable(lpf_idx) && $stable(dig_idx)));

    // R11: combined mode leaves the filter and digital tables alone
    assert_full_keeps_aux_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !split_mode) |=> ($stable(lpf_idx) && $stable(dig_idx)));

    // R2: exact case-1 subtraction when it fits
    assert_full_c1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !split_mode && ovl_adc_large && (ovl_lim_large || ovl_dig_sat)
         && lim_idx >= LMT_W'(cfg_step_c1))
        |=> lim_idx == $past(lim_idx) - LMT_W'($past(cfg_step_c1)));

    // R6: clamp at zero instead of wrapping
    assert_floor_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !split_mode && ovl_adc_large && (ovl_lim_large || ovl_dig_sat)
         && lim_idx < LMT_W'(cfg_step_c1))
        |=> lim_idx == '0);

    // R7: split-mode limiter steps are single indices and never rise
    assert_split_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && split_mode)
        |=> ((lim_idx == $past(lim_idx)) || (lim_idx + LMT_W'(1) == $past(lim_idx))));

    // R8: ADC overload at or below the limit drains the filter table
    assert_adc_lower_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && split_mode && (ovl_adc_large || ovl_adc_small) && !ovl_lim_large
         && lim_idx <= cfg_lim_floor && lpf_idx != '0)
        |=> ($stable(lim_idx) && lpf_idx + LPF_W'(1) == $past(lpf_idx)));
endmodule

// File: tb/test_gain_index_stepper.sv
module test_gain_index_stepper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       split_mode = 1'b0, step_en = 1'b0;
    logic       la = 1'b0, sa = 1'b0, ll = 1'b0, ds = 1'b0;
    logic [3:0] c1 = 4'd9;
    logic [2:0] c2 = 3'd5, c3 = 3'd2;
    logic [6:0] lmax = 7'd76, lfloor = 7'd40;
    logic [5:0] lpfi = 6'd24;
    logic [4:0] digi = 5'd15;
    logic [6:0] lim_idx;
    logic [5:0] lpf_idx;
    logic [4:0] dig_idx;

    always #5 clk = ~clk;

    gain_index_stepper i_gain_index_stepper (
        .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .step_en(step_en),
        .ovl_adc_large(la), .ovl_adc_small(sa), .ovl_lim_large(ll), .ovl_dig_sat(ds),
        .cfg_step_c1(c1), .cfg_step_c2(c2), .cfg_step_c3(c3),
        .cfg_lim_max(lmax), .cfg_lim_floor(lfloor),
        .cfg_lpf_init(lpfi), .cfg_dig_init(digi),
        .lim_idx(lim_idx), .lpf_idx(lpf_idx), .dig_idx(dig_idx)
    );

    typedef struct { int lim; int lpf; int dig; string tag; } exp_t;
    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    int m_lim = 0, m_lpf = 0, m_dig = 0;
    bit done = 0;

    function automatic int dec(int v, int s);
        return (v >= s) ? v - s : 0;
    endfunction

    task automatic drive(bit r, bit sp, bit en, bit a_l, bit a_s, bit l_l, bit d_s, string tag);
        exp_t e;
        int old_lim;
        @(negedge clk);
        rst_n = r; split_mode = sp; step_en = en;
        la = a_l; sa = a_s; ll = l_l; ds = d_s;
        old_lim = m_lim;
        if (!r) begin
            m_lim = lmax; m_lpf = lpfi; m_dig = digi;
        end else if (en && !sp) begin
            if (a_l && (l_l || d_s))    m_lim = dec(m_lim, c1);
            else if (a_l || l_l || d_s) m_lim = dec(m_lim, c2);
            else if (a_s)               m_lim = dec(m_lim, c3);
        end else if (en) begin
            if (l_l || ((a_l || a_s) && old_lim > lfloor)) m_lim = dec(m_lim, 1);
            if ((a_l || a_s) && old_lim <= lfloor)         m_lpf = dec(m_lpf, 1);
            if (d_s)                                       m_dig = dec(m_dig, 1);
        end
        e.lim = m_lim; e.lpf = m_lpf; e.dig = m_dig; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (lim_idx != e.lim || lpf_idx != e.lpf || dig_idx != e.dig) begin
                    n_bad++;
                    $display("FAIL %s: got lim=%0d lpf=%0d dig=%0d expected lim=%0d lpf=%0d dig=%0d",
                             e.tag, lim_idx, lpf_idx, dig_idx, e.lim, e.lpf, e.dig);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        drive(0, 0, 0, 0, 0, 0, 0, "R1 reset load");
        drive(0, 0, 0, 0, 0, 0, 0, "R1 reset load");
        // combined mode
        drive(1, 0, 1, 1, 0, 1, 0, "R2 adc+lim case1");
        drive(1, 0, 1, 1, 0, 0, 1, "R2 adc+sat case1");
        drive(1, 0, 1, 1, 0, 0, 0, "R3 adc large alone");
        drive(1, 0, 1, 0, 0, 1, 0, "R3 lim large alone");
        drive(1, 0, 1, 0, 0, 0, 1, "R3 sat alone R11");
        drive(1, 0, 1, 0, 1, 0, 0, "R4 small adc");
        drive(1, 0, 1, 0, 1, 1, 0, "R5 small+lim gives case2");
        drive(1, 0, 1, 1, 1, 1, 1, "R5 all flags case1 once");
        drive(1, 0, 1, 0, 0, 0, 0, "R10 strobe without flags");
        drive(1, 0, 0, 1, 1, 1, 1, "R10 flags without strobe");
        drive(1, 1, 0, 1, 1, 1, 1, "R10 split no strobe");
        for (int i = 0; i < 5; i++)
            drive(1, 0, 1, 1, 0, 1, 0, "R6 clamp combined");
        // split mode
        drive(0, 1, 0, 0, 0, 0, 0, "R1 reload after zero");
        drive(1, 1, 1, 0, 0, 1, 0, "R7 lim large split");
        drive(1, 1, 1, 1, 0, 0, 0, "R8 adc upper table");
        for (int i = 0; i < 33; i++)
            drive(1, 1, 1, 0, 0, 1, 0, "R7 walk down");
        drive(1, 1, 1, 1, 0, 0, 0, "R8 adc just above floor");
        drive(1, 1, 1, 1, 0, 0, 0, "R8 adc at floor to lpf");
        drive(1, 1, 1, 0, 1, 0, 0, "R8 small adc to lpf");
        drive(1, 1, 1, 0, 0, 0, 1, "R9 sat to dig");
        drive(1, 1, 1, 0, 1, 1, 0, "R7 R8 lim and lpf together");
        drive(1, 1, 1, 1, 0, 0, 1, "R9 sat with lpf");
        for (int i = 0; i < 20; i++)
            drive(1, 1, 1, 0, 0, 0, 1, "R6 R9 dig clamp");
        for (int i = 0; i < 24; i++)
            drive(1, 1, 1, 0, 1, 0, 0, "R6 R8 lpf clamp");
        drive(1, 0, 1, 0, 1, 0, 0, "R4 R11 combined after split");
        drive(1, 0, 0, 0, 0, 0, 0, "R10 idle");
        repeat (3) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule